// File: doc/BRIEF.md
# Device Participation Select

This block decides whether one device in a multi-device system takes part in a control cycle. Two active-low chip-select pins give hardware selection. One pin is meant to be shared by every device for broadcast cycles, and the other is decoded per device for local cycles. A software path adds a third way in. A soft-select register holds a disable bit and a 4-bit target page. A configuration register holds the device's own 4-bit page address. When software selection is enabled and the target page equals the device's own page, the device is selected without a dedicated select line. The three conditions are ORed together.

The decision is taken only at the start of a control cycle, which is the falling edge of the active-low cycle strobe. A three-state machine tracks the strobe. ST_WAIT_HIGH is entered on reset and moves to ST_ARMED once the strobe is seen high. ST_ARMED moves to ST_CYCLE on the first clock where the strobe is low. This ST_ARMED to ST_CYCLE transition is the sample, and the registered select output is loaded on it. ST_CYCLE returns to ST_ARMED when the strobe goes high again. All inputs are synchronous to `clk`.

Writes to the soft-select register are taken only while the device is currently selected by any path. This lets a broadcast cycle on the shared pin move software selection to another device, or switch it off. The configuration register belongs to the device alone and is always writable.

Top module: `devsel_top`

## Requirements
- R1: If `cs_glob_n` or `cs_local_n` is 0 at a sample, `sel_q` is 1 from the next clock.
- R2: If soft-select bit 4 is 0 and soft-select bits 3:0 equal the configuration page at a sample, `sel_q` becomes 1 even when both chip-select pins are 1.
- R3: The select result is the OR of the two pin conditions and the register match. If none of them holds at a sample, `sel_q` becomes 0. This includes the case where bit 4 is 0 but the pages differ.
- R4: While soft-select bit 4 is 1, the register path never selects the device, whatever the page values are.
- R5: A sample happens only on the first clock where `strobe_n` is 0 after a clock where it was 1, that is, on the ST_ARMED to ST_CYCLE transition. `sel_q` changes on that clock edge and at no other time, so pin and register changes while the strobe stays low, or while it stays high, have no effect on it.
- R6: A `dsel_wr` pulse loads `dsel_wdata` (bit 4 is the disable bit, bits 3:0 the page) only when the device is currently selected by any path, including by `cs_glob_n` alone. If the device is not selected, the write is ignored.
- R7: A `cfg_wr` pulse always loads `cfg_wdata` as the device's page address, and the new value takes part in the next sample.
- R8: Reset sets soft-select bit 4 to 1, both pages to 0 and `sel_q` to 0, and enters ST_WAIT_HIGH. A strobe that is already low when reset is released causes no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_n | input | 1 | Active-low cycle strobe; its falling edge samples the select |
| cs_glob_n | input | 1 | Shared active-low chip select |
| cs_local_n | input | 1 | Per-device active-low chip select |
| dsel_wr | input | 1 | Soft-select register write request |
| dsel_wdata | input | 5 | Bit 4 disables software selection, bits 3:0 give the target page |
| cfg_wr | input | 1 | Configuration page write |
| cfg_wdata | input | 4 | The device's own page address |
| sel_q | output | 1 | Registered participation decision |

## Verification
The assertions check on every cycle that `sel_q` moves only on a sample. They also check that a low chip-select pin at a sample forces selection, that a set disable bit with both pins high forces deselection, that a matching page selects the device, and that a soft-select write with the shared pin low is taken. The bench scenarios are needed for the rest. They show that writes made while the device is unselected are ignored, and that a strobe held low through reset causes no sample. They also show that configuration changes take effect on the following cycle, and that the decision holds steady across long random runs of pin and register activity while the strobe is held.

// File: rtl/devsel_pkg.sv
package devsel_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_HIGH = 2'd0,
        ST_ARMED     = 2'd1,
        ST_CYCLE     = 2'd2
    } strobe_state_e;
endpackage

// File: rtl/devsel_regs.sv
module devsel_regs #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_now,
    input  logic              dsel_wr,
    input  logic [PAGE_W:0]   dsel_wdata,
    input  logic              cfg_wr,
    input  logic [PAGE_W-1:0] cfg_wdata,
    output logic              soft_off_q,
    output logic [PAGE_W-1:0] soft_page_q,
    output logic [PAGE_W-1:0] cfg_page_q
);
    // soft-select register: writes gated by the present selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_off_q  <= 1'b1;
            soft_page_q <= '0;
        end else if (dsel_wr && sel_now) begin
            soft_off_q  <= dsel_wdata[PAGE_W];
            soft_page_q <= dsel_wdata[PAGE_W-1:0];
        end
    end

    // own page address: always writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_page_q <= '0;
        end else if (cfg_wr) begin
            cfg_page_q <= cfg_wdata;
        end
    end
endmodule

// File: rtl/devsel_decode.sv
module devsel_decode #(
    parameter int PAGE_W = 4
) (
    input  logic              cs_glob_n,
    input  logic              cs_local_n,
    input  logic              soft_off,
    input  logic [PAGE_W-1:0] soft_page,
    input  logic [PAGE_W-1:0] own_page,
    output logic              sel_now
);
    logic [PAGE_W-1:0] bit_eq;

    for (genvar i = 0; i < PAGE_W; i++) begin : g_cmp
        assign bit_eq[i] = ~(soft_page[i] ^ own_page[i]);
    end

    logic page_hit;
    assign page_hit = ~soft_off & (&bit_eq);

    always_comb begin
        sel_now = ~cs_glob_n | ~cs_local_n | page_hit;
    end
endmodule

// File: rtl/devsel_strobe_fsm.sv
module devsel_strobe_fsm
    import devsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    input  logic sel_now,
    output logic samp,
    output logic sel_q
);
    strobe_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        samp    = 1'b0;
        unique case (state_q)
            ST_WAIT_HIGH: if (strobe_n)  state_d = ST_ARMED;
            ST_ARMED: begin
                if (!strobe_n) begin
                    state_d = ST_CYCLE;
                    samp    = 1'b1;
                end
            end
            ST_CYCLE:     if (strobe_n)  state_d = ST_ARMED;
            default:      state_d = ST_WAIT_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_HIGH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= 1'b0;
        else if (samp) sel_q <= sel_now;
    end
endmodule

// File: rtl/devsel_top.sv
module devsel_top #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              cs_glob_n,
    input  logic              cs_local_n,
    input  logic              dsel_wr,
    input  logic [PAGE_W:0]   dsel_wdata,
    input  logic              cfg_wr,
    input  logic [PAGE_W-1:0] cfg_wdata,
    output logic              sel_q
);
    logic              sel_now;
    logic              samp;
    logic              soft_off_q;
    logic [PAGE_W-1:0] soft_page_q;
    logic [PAGE_W-1:0] cfg_page_q;

    devsel_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel_now(sel_now),
        .dsel_wr(dsel_wr), .dsel_wdata(dsel_wdata),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .soft_off_q(soft_off_q), .soft_page_q(soft_page_q),
        .cfg_page_q(cfg_page_q)
    );

    devsel_decode #(.PAGE_W(PAGE_W)) u_dec (
        .cs_glob_n(cs_glob_n), .cs_local_n(cs_local_n),
        .soft_off(soft_off_q), .soft_page(soft_page_q),
        .own_page(cfg_page_q), .sel_now(sel_now)
    );

    devsel_strobe_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n),
        .sel_now(sel_now), .samp(samp), .sel_q(sel_q)
    );
endmodule

// File: rtl/devsel_chk.sv
module devsel_chk #(
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_glob_n,
    input logic              cs_local_n,
    input logic              dsel_wr,
    input logic [PAGE_W:0]   dsel_wdata,
    input logic              samp,
    input logic              sel_q,
    input logic              soft_off_q,
    input logic [PAGE_W-1:0] soft_page_q,
    input logic [PAGE_W-1:0] cfg_page_q
);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !samp |=> $stable(sel_q));

    p_pin_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (samp && (!cs_glob_n || !cs_local_n)) |=> sel_q);

    p_soft_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (samp && cs_glob_n && cs_local_n && soft_off_q) |=> !sel_q);

    p_page_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (samp && !soft_off_q && soft_page_q == cfg_page_q) |=> sel_q);

    p_glob_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_wr && !cs_glob_n) |=>
            ({soft_off_q, soft_page_q} == $past(dsel_wdata)));
endmodule

bind devsel_top devsel_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_glob_n(cs_glob_n), .cs_local_n(cs_local_n),
    .dsel_wr(dsel_wr), .dsel_wdata(dsel_wdata), .samp(samp), .sel_q(sel_q),
    .soft_off_q(soft_off_q), .soft_page_q(soft_page_q), .cfg_page_q(cfg_page_q)
);

// File: tb/tb_devsel_top.sv
`timescale 1ns/1ps
module tb_devsel_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_n = 1'b1;
    logic       cs_glob_n = 1'b1;
    logic       cs_local_n = 1'b1;
    logic       dsel_wr = 1'b0;
    logic [4:0] dsel_wdata = '0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic       sel_q;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic       m_off = 1'b1;
    logic [3:0] m_spg = '0;
    logic [3:0] m_page = '0;
    logic       m_sel = 1'b0;
    logic       m_armed = 1'b0;

    always #4 clk = ~clk;

    devsel_top dut (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n),
        .cs_glob_n(cs_glob_n), .cs_local_n(cs_local_n),
        .dsel_wr(dsel_wr), .dsel_wdata(dsel_wdata),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .sel_q(sel_q)
    );

    function automatic logic want_sel(logic g, logic l, logic off,
                                      logic [3:0] sp, logic [3:0] pg);
        return !g || !l || (!off && sp == pg);
    endfunction

    task automatic check(string req, logic exp);
        checks++;
        if (sel_q !== exp) begin
            errors++;
            $display("FAIL %s: sel_q=%0b expected %0b at %0t", req, sel_q, exp, $time);
        end
    endtask

    task automatic cyc(string req, logic strb, logic g, logic l,
                       logic dw, logic [4:0] dd, logic cw, logic [3:0] cd);
        logic now;
        @(negedge clk);
        strobe_n = strb; cs_glob_n = g; cs_local_n = l;
        dsel_wr = dw; dsel_wdata = dd; cfg_wr = cw; cfg_wdata = cd;
        now = want_sel(g, l, m_off, m_spg, m_page);
        if (m_armed && !strb) m_sel = now;
        if (dw && now) begin m_off = dd[4]; m_spg = dd[3:0]; end
        if (cw) m_page = cd;
        m_armed = strb;
        @(posedge clk);
        #2;
        check(req, m_sel);
    endtask

    // a full strobe cycle: high then low, sampling with given pins
    task automatic sample(string req, logic g, logic l);
        cyc(req, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 4'd0);
        cyc(req, 1'b0, g, l, 1'b0, 5'd0, 1'b0, 4'd0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: sel_q=%0b expected completion", sel_q);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R8: strobe and pins low through reset
        strobe_n = 1'b0; cs_glob_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 check("R8 reset", 1'b0);
        @(negedge clk) rst_n = 1'b1;
        cyc("R8 no sample while low", 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 4'd0);
        cyc("R8 no sample while low", 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 4'd0);
        // R4: reset default disables soft path even with page 0 == 0
        sample("R4 default off", 1'b1, 1'b1);
        // R1
        sample("R1 glob", 1'b0, 1'b1);
        sample("R3 none", 1'b1, 1'b1);
        sample("R1 local", 1'b1, 1'b0);
        // R5: pin change while strobe held low has no effect
        cyc("R5 hold", 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 4'd0);
        cyc("R5 hold", 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 4'd0);
        // R5: low pins while strobe high
        cyc("R5 high", 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 4'd0);
        // R7: own page 5
        cyc("R7 cfg", 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 4'd5);
        // R6: write ignored while unselected
        cyc("R6 ignored", 1'b1, 1'b1, 1'b1, 1'b1, 5'h05, 1'b0, 4'd0);
        sample("R6 ignored write", 1'b1, 1'b1);
        // R6: write accepted with shared pin only
        cyc("R6 glob write", 1'b1, 1'b0, 1'b1, 1'b1, 5'h05, 1'b0, 4'd0);
        sample("R2 page hit", 1'b1, 1'b1);
        // R3: enabled but mismatched page
        cyc("R6 glob write", 1'b1, 1'b0, 1'b1, 1'b1, 5'h06, 1'b0, 4'd0);
        sample("R3 mismatch", 1'b1, 1'b1);
        // R7: move own page to match
        cyc("R7 cfg", 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 4'd6);
        sample("R7 new page", 1'b1, 1'b1);
        // R4: disable bit set with matching page
        cyc("R6 glob write", 1'b1, 1'b0, 1'b1, 1'b1, 5'h16, 1'b0, 4'd0);
        sample("R4 off", 1'b1, 1'b1);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic s, g, l, dw, cw;
            s  = ($urandom % 3) != 0;
            g  = ($urandom % 5) != 0;
            l  = ($urandom % 5) != 0;
            dw = ($urandom % 6) == 0;
            cw = ($urandom % 8) == 0;
            cyc("R3 random", s, g, l, dw, 5'($urandom), cw, 4'($urandom % 4));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule